// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card clock of an SD host from its base clock. Software supplies a divisor as an eight-bit select field plus two upper bits. A mode input picks how that divisor is read. In power-of-two mode the highest set bit of the eight-bit field chooses a division by a power of two. In linear mode the full ten-bit value N divides by 2N. A value of zero passes the base clock through unchanged in either mode. A preset-enable input replaces the software divisor with a preset value that is supplied from outside the block.

An internal clock enable starts a short settling timer, and the stable flag rises when that timer expires. The card clock leaves the block only while the card-clock enable and the stable flag are both high; at all other times it is held low. A new divisor is adopted only when the divided clock falls, so a high phase that is already running always completes at its full length.

Top module: `sd_card_clkgen`

## Requirements
- R1: While reset is held and right after it, `card_clk` and `int_clk_stable` are 0.
- R2: `int_clk_stable` rises on the 4th rising base-clock edge (parameter STABLE_CYC) at which `int_clk_en` is sampled high. It drops in the same instant that `int_clk_en` falls.
- R3: `card_clk` stays 0 whenever `card_clk_en` is 0 or `int_clk_stable` is 0.
- R4: With `ext_mode`=0 and exactly one bit k of `div_sel` set (01h..80h), `card_clk` is the base clock divided by 2^(k+1). Its high and low phases are each 2^k base cycles.
- R5: With `ext_mode`=0 and several bits of `div_sel` set, only the most significant set bit determines the divisor.
- R6: A divisor of zero in either mode passes the base clock to `card_clk`: high while the base clock is high, low while it is low.
- R7: With `ext_mode`=1, the divisor N = {`div_upper`,`div_sel`} from 1 to 3FFh gives a period of 2N base cycles, with N cycles high and N cycles low.
- R8: With `ext_mode`=0, `div_upper` has no effect on `card_clk`.
- R9: With `preset_en`=1, `preset_div` replaces {`div_upper`,`div_sel`}. The mode rules are unchanged, so power-of-two mode reads only `preset_div[7:0]`.
- R10: A divisor change is adopted at the next falling edge of the divided clock. A high phase in progress ends at its old full length, and the following phases use the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_mode | input | 1 | 0: power-of-two divisor, 1: linear ten-bit divisor |
| div_sel | input | 8 | Software divisor select, low bits |
| div_upper | input | 2 | Software divisor, upper bits (linear mode only) |
| preset_en | input | 1 | Take divisor from preset_div |
| preset_div | input | 10 | Preset divisor value |
| int_clk_en | input | 1 | Internal clock enable |
| card_clk_en | input | 1 | Card clock output enable |
| int_clk_stable | output | 1 | Internal clock settled |
| card_clk | output | 1 | Gated, divided card clock |

## Verification
Two events can fall in the same base cycle: a divisor rewrite and the falling boundary of the divided clock, where the new value is loaded. The bench rewrites the divisor a few samples into a high phase of a slow setting. It then counts the full length of that high phase at half-cycle resolution and expects the old length. It then measures the following high and low phases and expects the new length. The same half-cycle sampling also checks pass-through mode and every legal setting, comparing against lengths computed by a bench function.

// File: rtl/sdclk_pkg.sv
// Shared types for the card clock divider.
// Assumes: nothing beyond IEEE 1800-2017.
package sdclk_pkg;
    // How the divisor field is interpreted.
    typedef enum logic {
        DIV_POW2   = 1'b0,
        DIV_LINEAR = 1'b1
    } div_mode_e;
endpackage

// File: rtl/sdclk_div_decode.sv
// Divisor decoder: chooses the software or preset divisor, then turns it into a
// half-period length in base cycles (0 means pass-through).
// Assumes: the inputs are synchronous to clk; clk/rst_n are used only by the assertions.
module sdclk_div_decode
    import sdclk_pkg::*;
#(
    parameter int SEL_W = 8,
    parameter int UP_W  = 2,
    localparam int DIV_W = SEL_W + UP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  div_mode_e        mode_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [UP_W-1:0]  up_i,
    input  logic             preset_en_i,
    input  logic [DIV_W-1:0] preset_i,
    output logic [DIV_W-1:0] half_o
);
    logic [DIV_W-1:0] src;
    logic [SEL_W-1:0] top_bit;

    // Pick the divisor source.
    assign src = preset_en_i ? preset_i : {up_i, sel_i};

    // Keep only the most significant set bit of the low field (power-of-two mode).
    for (genvar i = 0; i < SEL_W; i++) begin : g_msb
        if (i == SEL_W - 1) begin : g_top
            assign top_bit[i] = src[i];
        end else begin : g_low
            assign top_bit[i] = src[i] & ~(|src[SEL_W-1:i+1]);
        end
    end

    // Half period: 2^k for bit k in power-of-two mode, N in linear mode.
    always_comb begin
        if (mode_i == DIV_LINEAR) begin
            half_o = src;
        end else begin
            half_o = {{UP_W{1'b0}}, top_bit};
        end
    end

    AST_POW2_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == DIV_POW2) |-> $onehot0(half_o)); // R5
    AST_POW2_NO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == DIV_POW2) |-> (half_o[DIV_W-1:SEL_W] == '0)); // R8
endmodule

// File: rtl/sdclk_stable_timer.sv
// Settling timer: raises the stable flag after STABLE_CYC sampled-high cycles of
// the internal enable, and drops it at once when the enable falls.
// Assumes: STABLE_CYC >= 2.
module sdclk_stable_timer #(
    parameter int STABLE_CYC = 4,
    localparam int CW = $clog2(STABLE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic stable_o
);
    logic [CW-1:0] cnt_q;
    logic          done_q;

    // Count enabled cycles and latch completion until the enable drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == CW'(STABLE_CYC - 1)) begin
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Immediate clear when the enable falls.
    assign stable_o = done_q & en_i;

    AST_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(en_i)); // R2
    AST_STABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> !done_q); // R2
endmodule

// File: rtl/sdclk_phase_gen.sv
// Phase generator: toggles the divided clock every 'half' base cycles, adopts a
// new half length only at a falling boundary, and gates either the divided clock
// or the raw base clock onto the output through falling-edge enable flops.
// Assumes: run_i and target_i change away from the rising edge of clk.
module sdclk_phase_gen #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] target_i,
    output logic             card_clk_o
);
    logic [DIV_W-1:0] act_q;
    logic [DIV_W-1:0] cnt_q;
    logic             div_q;
    logic             byp_gate_q;
    logic             div_gate_q;

    // Half-period counter, divided clock and boundary-aligned divisor load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
            cnt_q <= '0;
            div_q <= 1'b0;
        end else if (!run_i || act_q == '0) begin
            act_q <= target_i;
            cnt_q <= '0;
            div_q <= 1'b0;
        end else if (cnt_q == act_q - 1'b1) begin
            cnt_q <= '0;
            div_q <= ~div_q;
            if (div_q) begin
                act_q <= target_i;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Output path enables, updated while the base clock is low.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            byp_gate_q <= 1'b0;
            div_gate_q <= 1'b0;
        end else begin
            byp_gate_q <= run_i && (act_q == '0);
            div_gate_q <= run_i && (act_q != '0);
        end
    end

    // Glitch-free output combine.
    assign card_clk_o = (clk & byp_gate_q) | (div_q & div_gate_q);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q != '0) |-> (cnt_q < act_q)); // R7
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !div_q); // R3
    AST_SWITCH_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && $past(act_q) != '0 && act_q != $past(act_q))
        |-> (!div_q && $past(div_q))); // R10
    AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        !(byp_gate_q && div_gate_q)); // R6
endmodule

// File: rtl/sd_card_clkgen.sv
// Card clock generator top: divisor decode, settling timer and gated phase
// generator. The card clock runs only while card enable and stable are high.
// Assumes: clk is the base clock; all control inputs are synchronous to it.
module sd_card_clkgen #(
    parameter int SEL_W      = 8,
    parameter int UP_W       = 2,
    parameter int STABLE_CYC = 4,
    localparam int DIV_W = SEL_W + UP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode,
    input  logic [SEL_W-1:0] div_sel,
    input  logic [UP_W-1:0]  div_upper,
    input  logic             preset_en,
    input  logic [DIV_W-1:0] preset_div,
    input  logic             int_clk_en,
    input  logic             card_clk_en,
    output logic             int_clk_stable,
    output logic             card_clk
);
    import sdclk_pkg::*;

    logic [DIV_W-1:0] half_len;
    logic             run;
    div_mode_e        mode;

    // Map the mode pin onto the divisor interpretation.
    assign mode = ext_mode ? DIV_LINEAR : DIV_POW2;

    sdclk_div_decode #(.SEL_W(SEL_W), .UP_W(UP_W)) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .sel_i       (div_sel),
        .up_i        (div_upper),
        .preset_en_i (preset_en),
        .preset_i    (preset_div),
        .half_o      (half_len)
    );

    sdclk_stable_timer #(.STABLE_CYC(STABLE_CYC)) u_stable (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (int_clk_en),
        .stable_o (int_clk_stable)
    );

    // Output may run only with both enables satisfied.
    assign run = card_clk_en & int_clk_stable;

    sdclk_phase_gen #(.DIV_W(DIV_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .target_i   (half_len),
        .card_clk_o (card_clk)
    );
endmodule

// File: tb/test_sd_card_clkgen.sv
module test_sd_card_clkgen;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 6000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_mode = 1'b0;
    logic [7:0] div_sel = '0;
    logic [1:0] div_upper = '0;
    logic       preset_en = 1'b0;
    logic [9:0] preset_div = '0;
    logic       int_clk_en = 1'b0;
    logic       card_clk_en = 1'b0;
    logic       int_clk_stable;
    logic       card_clk;

    int n_tests = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sd_card_clkgen i_sd_card_clkgen (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .div_sel(div_sel),
        .div_upper(div_upper), .preset_en(preset_en), .preset_div(preset_div),
        .int_clk_en(int_clk_en), .card_clk_en(card_clk_en),
        .int_clk_stable(int_clk_stable), .card_clk(card_clk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected phase length in half-cycle samples.
    function automatic int exp_samples(input bit ext, input logic [7:0] sel,
                                       input logic [1:0] up, input bit pe,
                                       input logic [9:0] pd);
        logic [9:0] src;
        int half;
        src = pe ? pd : {up, sel};
        half = 0;
        if (ext) begin
            half = int'(src);
        end else begin
            for (int k = 0; k < 8; k++) if (src[k]) half = 1 << k;
        end
        return (half == 0) ? 1 : 2 * half;
    endfunction

    task automatic half_step();
        @(clk);
        #1;
    endtask

    task automatic wait_level(input logic lvl, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < TMO; i++) begin
            if (card_clk == lvl) begin ok = 1'b1; break; end
            half_step();
        end
    endtask

    task automatic count_level(input logic lvl, output int n);
        n = 0;
        while (card_clk == lvl && n < TMO) begin
            n++;
            half_step();
        end
    endtask

    task automatic measure(output int hi, output int lo);
        bit ok;
        hi = -1; lo = -1;
        wait_level(1'b0, ok);
        if (ok) wait_level(1'b1, ok);
        if (ok) begin
            count_level(1'b1, hi);
            count_level(1'b0, lo);
        end
    endtask

    task automatic run_cfg(input string req, input bit ext, input logic [7:0] sel,
                           input logic [1:0] up, input bit pe, input logic [9:0] pd);
        int hi, lo, e;
        ext_mode = ext; div_sel = sel; div_upper = up; preset_en = pe; preset_div = pd;
        e = exp_samples(ext, sel, up, pe, pd);
        measure(hi, lo);
        measure(hi, lo);
        chk(hi == e, {req, " high"}, hi, e);
        chk(lo == e, {req, " low"}, lo, e);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int hi, lo, seen;
        logic [7:0] s;
        logic [9:0] n;
        void'($urandom(32'h5D17));
        repeat (3) @(posedge clk);
        #1;
        chk(card_clk == 0 && int_clk_stable == 0, "R1 during reset", card_clk, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(card_clk == 0 && int_clk_stable == 0, "R1 after reset", int_clk_stable, 0);

        // R2: settling count
        @(negedge clk); #1; int_clk_en = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            @(posedge clk); #1;
            chk(int_clk_stable == (i == 4), $sformatf("R2 stable after %0d edges", i),
                int_clk_stable, (i == 4));
        end
        @(negedge clk); #1; int_clk_en = 1'b0; #1;
        chk(int_clk_stable == 0, "R2 immediate clear", int_clk_stable, 0);

        // R3: no output while stable low
        card_clk_en = 1'b1; div_sel = 8'h01; seen = 0;
        for (int i = 0; i < 40; i++) begin half_step(); seen += card_clk; end
        chk(seen == 0, "R3 output off while not stable", seen, 0);
        int_clk_en = 1'b1;
        repeat (6) @(posedge clk);
        #1;
        // R3: no output while card enable low
        card_clk_en = 1'b0; seen = 0;
        repeat (4) half_step();
        for (int i = 0; i < 40; i++) begin half_step(); seen += card_clk; end
        chk(seen == 0, "R3 output off while card enable low", seen, 0);
        card_clk_en = 1'b1;

        // R4: every single-bit legacy setting
        for (int k = 0; k < 8; k++) run_cfg($sformatf("R4 sel bit %0d", k), 1'b0, 8'(1 << k), 2'b00, 1'b0, '0);
        // R6: pass-through in both modes
        run_cfg("R6 legacy zero", 1'b0, 8'h00, 2'b00, 1'b0, '0);
        run_cfg("R6 linear zero", 1'b1, 8'h00, 2'b00, 1'b0, '0);
        // R5: multi-bit legacy values
        for (int i = 0; i < 4; i++) begin
            s = 8'($urandom) | 8'h01 | 8'(1 << (1 + ($urandom % 7)));
            run_cfg($sformatf("R5 sel %02h", s), 1'b0, s, 2'b00, 1'b0, '0);
        end
        // R8: upper bits ignored in legacy mode
        run_cfg("R8 upper ignored", 1'b0, 8'h04, 2'b11, 1'b0, '0);
        // R7: linear corners and random values
        run_cfg("R7 N=1", 1'b1, 8'h01, 2'b00, 1'b0, '0);
        run_cfg("R7 N=2", 1'b1, 8'h02, 2'b00, 1'b0, '0);
        run_cfg("R7 N=3", 1'b1, 8'h03, 2'b00, 1'b0, '0);
        run_cfg("R7 N=3FF", 1'b1, 8'hFF, 2'b11, 1'b0, '0);
        for (int i = 0; i < 6; i++) begin
            n = 10'(1 + ($urandom % 400));
            run_cfg($sformatf("R7 N=%0h", n), 1'b1, n[7:0], n[9:8], 1'b0, '0);
        end
        // R9: preset override
        run_cfg("R9 preset linear", 1'b1, 8'h01, 2'b00, 1'b1, 10'h105);
        run_cfg("R9 preset legacy", 1'b0, 8'h01, 2'b00, 1'b1, 10'h310);

        // R10: change during a high phase
        run_cfg("R10 setup", 1'b1, 8'h05, 2'b00, 1'b0, '0);
        begin
            bit ok;
            wait_level(1'b0, ok);
            wait_level(1'b1, ok);
            hi = 0;
            repeat (3) begin hi++; half_step(); end
            div_sel = 8'h02;
            count_level(1'b1, lo);
            chk(hi + lo == 10, "R10 running high keeps old length", hi + lo, 10);
            count_level(1'b0, lo);
            chk(lo == 4, "R10 next low uses new length", lo, 4);
            count_level(1'b1, hi);
            chk(hi == 4, "R10 next high uses new length", hi, 4);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule